// File: doc/BRIEF.md
# Four-Plane Display Memory Write Path

This block sits between a byte-wide processor bus and a display memory built from several byte-wide planes that all answer to the same address. Two indexed register pairs sit on the I/O side. Each pair has an index port that selects an internal register and a data port that reaches the selected register. The sequencer pair holds the per-plane write enable mask. The graphics pair holds the write-mode register and a read-plane select register.

On the memory side, every processor read captures the addressed byte of every plane into a per-plane latch at the same time. The read data bus returns the byte of the plane named by the read-plane select register. A processor write in direct mode stores the bus byte into every enabled plane. In copy mode the bus byte is ignored, and each enabled plane receives its own latch. One read followed by one write therefore moves a full multi-plane pixel group from one address to another.

The plane stores are small arrays inside the block. Software works the usual way: it sets an index once and then writes the data port as often as it needs.

Top module: `planar_write_path`

## Requirements
- R1: After reset, both index registers read 0x00, the plane mask reads 0x0F, the write-mode register reads 0x00, the read-plane select register reads 0x00, and mem_rdata is 0x00.
- R2: The sequencer index port is at I/O address 0x3C4 and its data port at 0x3C5. The graphics index port is at 0x3CE and its data port at 0x3CF. An index keeps its value until it is rewritten, so repeated data-port writes reach the same register. Index and data ports read back their contents. A data-port read at an unassigned index returns 0x00, and a data-port write at an unassigned index changes nothing.
- R3: The plane mask is sequencer register 2. Bit n set enables writes to plane n. All 16 mask values are legal, and a plane whose bit is clear keeps its contents on a write.
- R4: The write-mode register is graphics register 5, and its bits 1:0 pick the write mode. All eight bits are stored and read back unchanged.
- R5: In write modes 0, 2 and 3, a memory write stores mem_wdata unchanged into every enabled plane at mem_addr.
- R6: A memory read loads every plane's byte at mem_addr into that plane's latch. On the next cycle mem_rdata holds the byte of the plane given by bits 1:0 of graphics register 4.
- R7: In write mode 1, a memory write stores each enabled plane's latch into that plane at mem_addr, and mem_wdata has no effect.
- R8: When mem_rd and mem_wr are high in the same cycle, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational, 0 when not addressed |
| mem_wr | input | 1 | Display memory write strobe |
| mem_rd | input | 1 | Display memory read strobe |
| mem_addr | input | ADDR_W | Display memory address shared by all planes |
| mem_wdata | input | DATA_W | Display memory write data |
| mem_rdata | output | DATA_W | Byte of the selected plane from the last read |

## Verification
The bench builds the block with four planes and a 4-bit address, so each plane has 16 bytes. At that size every plane can be read back through the read-plane select after each phase, and the comparison runs against a model of all 64 bytes. The reduced depth lets the bench sweep all 16 mask values under direct writes and again under latch copies, and also exercise write modes 2 and 3 and the simultaneous read and write case. The contents of every plane are checked after each of these phases.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

   // I/O port map
   localparam logic [15:0] SEQ_IDX_PORT = 16'h03C4;
   localparam logic [15:0] GFX_IDX_PORT = 16'h03CE;

   // internal register indices
   localparam logic [7:0] SEQ_MASK_REG = 8'h02;
   localparam logic [7:0] GFX_RSEL_REG = 8'h04;
   localparam logic [7:0] GFX_MODE_REG = 8'h05;

   typedef enum logic [1:0] {
      WM_DIRECT = 2'd0,
      WM_COPY   = 2'd1,
      WM_RSV2   = 2'd2,
      WM_RSV3   = 2'd3
   } wmode_e;

endpackage

// File: rtl/pwp_reg_pair.sv
module pwp_reg_pair #(
   parameter logic [15:0]          IDX_PORT = 16'h03C4,
   parameter int                   NREGS    = 1,
   parameter logic [NREGS*8-1:0]   IDX_LIST = '0,
   parameter logic [NREGS*8-1:0]   RST_LIST = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               rd,
   input  logic [15:0]        addr,
   input  logic [7:0]         wdata,
   output logic [7:0]         rd_data,
   output logic [7:0]         idx_q,
   output logic [NREGS*8-1:0] regs_q
);

   localparam logic [15:0] DAT_PORT = IDX_PORT + 16'd1;

   if (NREGS < 1) begin : g_bad_nregs
      $error("pwp_reg_pair: NREGS must be at least 1");
   end

   logic          idx_sel;
   logic          dat_sel;
   logic [NREGS-1:0] hit;

   assign idx_sel = (addr == IDX_PORT);
   assign dat_sel = (addr == DAT_PORT);

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= 8'h00;
      else if (wr && idx_sel)
         idx_q <= wdata;
   end

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      assign hit[r] = (idx_q == IDX_LIST[r*8 +: 8]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[r*8 +: 8] <= RST_LIST[r*8 +: 8];
         else if (wr && dat_sel && hit[r])
            regs_q[r*8 +: 8] <= wdata;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      if (rd && idx_sel)
         rd_data = idx_q;
      else if (rd && dat_sel) begin
         for (int r = 0; r < NREGS; r++)
            if (hit[r]) rd_data = rd_data | regs_q[r*8 +: 8];
      end
   end

endmodule

// File: rtl/pwp_lane.sv
module pwp_lane #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              copy_mode,
   input  logic              wr_en,
   input  logic              ld_latch,
   output logic [DATA_W-1:0] q,
   output logic [DATA_W-1:0] latch_q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];
   logic [DATA_W-1:0] wr_data;

   assign q       = store[addr];
   assign wr_data = copy_mode ? latch_q : cpu_data;

   always_ff @(posedge clk) begin
      if (wr_en)
         store[addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         latch_q <= '0;
      else if (ld_latch)
         latch_q <= q;
   end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
   import pwp_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [15:0]       io_addr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              mem_wr,
   input  logic              mem_rd,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] mem_rdata
);

   localparam int SEL_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1;
   localparam logic [7:0] MASK_RST = 8'((1 << NUM_PLANES) - 1);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("planar_write_path: DATA_W must be 8");
   end
   if (NUM_PLANES < 2 || NUM_PLANES > 8) begin : g_bad_planes
      $error("planar_write_path: NUM_PLANES must be 2..8");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("planar_write_path: ADDR_W must be 1..10");
   end

   logic [7:0]  seq_rdata, gfx_rdata;
   logic [7:0]  seq_idx, gfx_idx;
   logic [7:0]  seq_regs;
   logic [15:0] gfx_regs;

   pwp_reg_pair #(
      .IDX_PORT (SEQ_IDX_PORT),
      .NREGS    (1),
      .IDX_LIST (SEQ_MASK_REG),
      .RST_LIST (MASK_RST)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (io_wr),
      .rd      (io_rd),
      .addr    (io_addr),
      .wdata   (io_wdata),
      .rd_data (seq_rdata),
      .idx_q   (seq_idx),
      .regs_q  (seq_regs)
   );

   pwp_reg_pair #(
      .IDX_PORT (GFX_IDX_PORT),
      .NREGS    (2),
      .IDX_LIST ({GFX_MODE_REG, GFX_RSEL_REG}),
      .RST_LIST (16'h0000)
   ) u_gfx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (io_wr),
      .rd      (io_rd),
      .addr    (io_addr),
      .wdata   (io_wdata),
      .rd_data (gfx_rdata),
      .idx_q   (gfx_idx),
      .regs_q  (gfx_regs)
   );

   assign io_rdata = seq_rdata | gfx_rdata;

   logic [NUM_PLANES-1:0] mask;
   wmode_e                mode;
   logic [SEL_W-1:0]      rsel;
   logic                  copy_mode;
   logic                  wr_go;
   logic                  unused_cfg;

   assign mask      = seq_regs[NUM_PLANES-1:0];
   assign rsel      = gfx_regs[SEL_W-1:0];
   assign mode      = wmode_e'(gfx_regs[9:8]);
   assign copy_mode = (mode == WM_COPY);
   assign wr_go     = mem_wr && !mem_rd;
   assign unused_cfg = ^{seq_regs, gfx_regs, gfx_idx};

   logic [NUM_PLANES-1:0][DATA_W-1:0] lane_q;
   logic [NUM_PLANES-1:0][DATA_W-1:0] latch_q;

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_lane
      pwp_lane #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .addr      (mem_addr),
         .cpu_data  (mem_wdata),
         .copy_mode (copy_mode),
         .wr_en     (wr_go && mask[p]),
         .ld_latch  (mem_rd),
         .q         (lane_q[p]),
         .latch_q   (latch_q[p])
      );
   end

   logic [DATA_W-1:0] sel_byte;

   always_comb begin
      sel_byte = lane_q[0];
      for (int p = 0; p < NUM_PLANES; p++)
         if (rsel == SEL_W'(p)) sel_byte = lane_q[p];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mem_rdata <= '0;
      else if (mem_rd)
         mem_rdata <= sel_byte;
   end

endmodule

// File: rtl/pwp_chk.sv
module pwp_chk
   import pwp_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int DATA_W     = 8,
   parameter int NUM_PLANES = 4,
   parameter int SEL_W      = 2
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              io_wr,
   input logic [15:0]                       io_addr,
   input logic                              mem_wr,
   input logic                              mem_rd,
   input logic [ADDR_W-1:0]                 mem_addr,
   input logic [DATA_W-1:0]                 mem_wdata,
   input logic [DATA_W-1:0]                 mem_rdata,
   input logic [7:0]                        seq_idx,
   input logic [NUM_PLANES-1:0]             mask,
   input logic                              copy_mode,
   input logic [SEL_W-1:0]                  rsel,
   input logic [NUM_PLANES-1:0][DATA_W-1:0] lane_q,
   input logic [NUM_PLANES-1:0][DATA_W-1:0] latch_q
);

   // R2
   seq_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == SEQ_IDX_PORT) |=> $stable(seq_idx));

   // R6
   rd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> mem_rdata == latch_q[$past(rsel)]);

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_pl
      // R3 R8
      plane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_wr && (mem_rd || !mask[p])
         |=> (mem_addr != $past(mem_addr)) || (lane_q[p] == $past(lane_q[p])));

      // R5
      direct_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_wr && !mem_rd && mask[p] && !copy_mode
         |=> (mem_addr != $past(mem_addr)) || (lane_q[p] == $past(mem_wdata)));

      // R7
      copy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_wr && !mem_rd && mask[p] && copy_mode
         |=> (mem_addr != $past(mem_addr)) || (lane_q[p] == $past(latch_q[p])));
   end

endmodule

bind planar_write_path pwp_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .NUM_PLANES (NUM_PLANES),
   .SEL_W      (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_wr     (io_wr),
   .io_addr   (io_addr),
   .mem_wr    (mem_wr),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .seq_idx   (seq_idx),
   .mask      (mask),
   .copy_mode (copy_mode),
   .rsel      (rsel),
   .lane_q    (lane_q),
   .latch_q   (latch_q)
);

// File: tb/tb_planar_write_path.sv
module tb_planar_write_path;

   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int NP    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_wr = 1'b0, io_rd = 1'b0;
   logic [15:0]   io_addr = '0;
   logic [7:0]    io_wdata = '0;
   logic [7:0]    io_rdata;
   logic          mem_wr = 1'b0, mem_rd = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [7:0]    mem_wdata = '0;
   logic [7:0]    mem_rdata;

   always #4 clk = ~clk;

   planar_write_path #(.ADDR_W(AW), .DATA_W(8), .NUM_PLANES(NP)) dut (
      .clk(clk), .rst_n(rst_n),
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int fails  = 0;

   logic [7:0] ref_m [NP][DEPTH];
   logic [7:0] ref_l [NP];
   logic [3:0] mask_r = 4'hF;
   logic [1:0] mode_r = 2'd0;

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] v);
      io_write(16'h03C4, 8'h02);
      io_write(16'h03C5, v);
      mask_r = v[3:0];
   endtask

   task automatic set_gfx(input logic [7:0] idx, input logic [7:0] v);
      io_write(16'h03CE, idx);
      io_write(16'h03CF, v);
      if (idx == 8'h05) mode_r = v[1:0];
   endtask

   task automatic mem_write(input int a, input logic [7:0] d);
      @(negedge clk);
      mem_addr = AW'(a); mem_wdata = d; mem_wr = 1'b1;
      @(negedge clk);
      mem_wr = 1'b0;
      for (int p = 0; p < NP; p++)
         if (mask_r[p]) ref_m[p][a] = (mode_r == 2'd1) ? ref_l[p] : d;
   endtask

   task automatic mem_read(input int a, output logic [7:0] d);
      @(negedge clk);
      mem_addr = AW'(a); mem_rd = 1'b1;
      @(negedge clk);
      mem_rd = 1'b0;
      d = mem_rdata;
      for (int p = 0; p < NP; p++) ref_l[p] = ref_m[p][a];
   endtask

   task automatic verify_all(input string tag);
      logic [7:0] got;
      for (int p = 0; p < NP; p++) begin
         set_gfx(8'h04, 8'(p));
         for (int a = 0; a < DEPTH; a++) begin
            mem_read(a, got);
            check(tag, got, ref_m[p][a]);
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      for (int p = 0; p < NP; p++) ref_l[p] = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 mem_rdata", mem_rdata, 8'h00);
      io_read(16'h03C4, v); check("R1 seq index", v, 8'h00);
      io_read(16'h03CE, v); check("R1 gfx index", v, 8'h00);
      io_write(16'h03C4, 8'h02);
      io_read(16'h03C5, v); check("R1 mask", v, 8'h0F);
      io_write(16'h03CE, 8'h05);
      io_read(16'h03CF, v); check("R1 mode", v, 8'h00);
      io_write(16'h03CE, 8'h04);
      io_read(16'h03CF, v); check("R1 read select", v, 8'h00);

      // R2 unassigned index reads zero, write there ignored
      io_write(16'h03C4, 8'h07);
      io_read(16'h03C5, v); check("R2 unassigned read", v, 8'h00);
      io_write(16'h03C5, 8'hAA);
      io_write(16'h03C4, 8'h02);
      io_read(16'h03C5, v); check("R2 unassigned write ignored", v, 8'h0F);

      // R2 index holds across repeated data writes
      io_write(16'h03C5, 8'h03);
      io_write(16'h03C5, 8'h05);
      io_read(16'h03C5, v); check("R2 repeated data write", v, 8'h05);
      io_read(16'h03C4, v); check("R2 index held", v, 8'h02);

      // R5 direct fill of all planes, then per-plane writes
      set_mask(8'h0F);
      for (int a = 0; a < DEPTH; a++) mem_write(a, 8'(a * 17 + 3));
      for (int p = 0; p < NP; p++) begin
         set_mask(8'(1 << p));
         for (int a = 0; a < DEPTH; a++)
            if (((a + p) % 3) != 0) mem_write(a, 8'(p * 64 + a * 3 + 1));
      end
      verify_all("R5 direct fill");

      // R3 every mask value
      for (int m = 0; m < 16; m++) begin
         set_mask(8'(m));
         mem_write(m, 8'(8'hA0 + m));
      end
      verify_all("R3 mask sweep");

      // R4 mode register stores all bits
      set_gfx(8'h05, 8'hFD);
      io_read(16'h03CF, v); check("R4 mode readback", v, 8'hFD);

      // R7 copy mode under every mask, data bus ignored; R6 latches
      for (int m = 0; m < 16; m++) begin
         mem_read((m + 5) % DEPTH, v);
         set_mask(8'(m));
         mem_write(m, 8'h55 ^ 8'(m));
      end
      verify_all("R7 copy sweep");

      // R5 reserved modes behave as direct
      set_mask(8'h0F);
      set_gfx(8'h05, 8'h02);
      mem_write(0, 8'h9C);
      set_gfx(8'h05, 8'h03);
      mem_write(1, 8'h6B);
      set_gfx(8'h05, 8'h00);
      set_gfx(8'h04, 8'h02);
      mem_read(0, v); check("R5 mode 2 write", v, 8'h9C);
      mem_read(1, v); check("R5 mode 3 write", v, 8'h6B);

      // R8 simultaneous read and write: read done, write dropped
      @(negedge clk);
      mem_addr = AW'(2); mem_wdata = 8'hEE; mem_rd = 1'b1; mem_wr = 1'b1;
      @(negedge clk);
      mem_rd = 1'b0; mem_wr = 1'b0;
      check("R8 read performed", mem_rdata, ref_m[2][2]);
      for (int p = 0; p < NP; p++) ref_l[p] = ref_m[p][2];
      verify_all("R8 write dropped");

      // R6 latch copy into another address with selected plane readout
      set_gfx(8'h05, 8'h01);
      mem_read(9, v);
      check("R6 read of selected plane", v, ref_m[3][9]);
      mem_write(12, 8'h00);
      verify_all("R6 latch copy");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule